// File: doc/BRIEF.md
# Dual-Action Capture/Compare Timer Channel

This block is one timer channel that either measures an input pin against a free-running time-base value or generates waveforms on an output pin from that time base. It holds two data registers, A and B. Register B is built from two physical halves, B1 and B2. The operating mode decides which half software reads and writes, and whether a write lands in both halves.

The channel is driven as a state machine whose states are the seven operating modes: OFF, PWCAP (input pulse-width capture), PERCAP (input period capture), CAP (input capture on any edge), OCB (output compare on B), OCAB (output compare on A and B) and PWM. The only transitions are software writes to the control register. Each write moves the channel from its current mode straight to the coded mode, and a write of the reserved code 7 moves it to OFF. Every mode change disarms both comparators.

Software reaches the channel through one register port with a shared address. Writes take effect at the clock edge. Reads are combinational.

Top module: `dacc_channel`

## Requirements
- R1: In OFF mode, a write to B (address 2) loads both B1 and B2. A read of B returns B1. After a switch to a capture mode, a read of B returns the same value from B2.
- R2: After reset the mode is OFF, the control, A, B and flag reads are all 0, and pin_out is 0.
- R3: In PWCAP mode, the selected leading edge stores the time base in hidden B1, and the visible B does not change. The following opposite edge stores the time base in A, moves B1 into B2 so that B shows the leading-edge time, and sets flag A.
- R4: In PERCAP mode, each selected edge stores the time base in B, moves the previous B value into A, and sets flag B. Control bit 3 selects the edge: 0 selects rising and 1 selects falling.
- R5: In CAP mode, every edge of pin_in stores the time base in B and sets flag B.
- R6: In OCB and OCAB modes, a write to B arms the B comparator, and in OCAB a write to A arms the A comparator. An armed comparator matches once, when the time base equals its register, and then disarms. In OCAB, an A match sets pin_out and a B match clears it.
- R7: In OCB mode, a B match drives pin_out to the value of control bit 4.
- R8: In PWM mode, a write to B goes to B1, and a read of B returns B1. An A match sets pin_out and copies B1 into B2. A match of the time base with B2 clears pin_out. A B write in mid-period therefore takes effect only after the next A match.
- R9: Flags are read at address 3, with bit 0 for A and bit 1 for B. Each flag is sticky and is cleared by writing 1 to its bit. Every capture or match event sets the flag of its register.
- R10: In OFF, PWCAP, PERCAP and CAP modes, pin_out is 0 from the second clock edge after the mode write. The reserved mode code 7 reads back as 0.
- R11: The control register is at address 0, with the mode in bits 2:0 (0 OFF, 1 PWCAP, 2 PERCAP, 3 CAP, 4 OCB, 5 OCAB, 6 PWM), the edge select in bit 3 and the OCB level in bit 4. Register A is at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbase | input | TW | Time-base value |
| pin_in | input | 1 | Input pin, sampled every clock |
| pin_out | output | 1 | Output pin, registered |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both read and write |
| wr_data | input | TW | Write data |
| rd_data | output | TW | Combinational read data |

## Verification
A wrong B1/B2 state cannot be seen directly. It shows up only later, at the point where the mode turns the hidden half into the visible one. A broken mirror shows on the first B read after leaving OFF. A missed or early PWM copy shows on pin_out at the next B2 match, one period late or early. A comparator that stays armed after its match shows on pin_out or flag B the next time the time base reaches the same value. The bench therefore drives the time base to chosen values and re-visits stale match values after each match.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    typedef enum logic [2:0] {
        M_OFF    = 3'd0,
        M_PWCAP  = 3'd1,
        M_PERCAP = 3'd2,
        M_CAP    = 3'd3,
        M_OCB    = 3'd4,
        M_OCAB   = 3'd5,
        M_PWM    = 3'd6
    } mode_e;

    localparam int AW = 2;
    localparam logic [AW-1:0] A_CTRL = 2'd0;
    localparam logic [AW-1:0] A_REGA = 2'd1;
    localparam logic [AW-1:0] A_REGB = 2'd2;
    localparam logic [AW-1:0] A_FLAG = 2'd3;

    function automatic logic drives_pin(mode_e m);
        return (m == M_OCB) || (m == M_OCAB) || (m == M_PWM);
    endfunction

    function automatic logic is_oc(mode_e m);
        return (m == M_OCB) || (m == M_OCAB);
    endfunction

    function automatic mode_e decode_mode(logic [2:0] code);
        mode_e m;
        unique case (code)
            3'd1:    m = M_PWCAP;
            3'd2:    m = M_PERCAP;
            3'd3:    m = M_CAP;
            3'd4:    m = M_OCB;
            3'd5:    m = M_OCAB;
            3'd6:    m = M_PWM;
            default: m = M_OFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/dacc_edge.sv
module dacc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic fall_sel,
    output logic lead,
    output logic trail,
    output logic any_edge
);
    logic pin_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_in;
    end

    always_comb begin
        rise     = pin_in & ~pin_q;
        fall     = ~pin_in & pin_q;
        lead     = fall_sel ? fall : rise;
        trail    = fall_sel ? rise : fall;
        any_edge = rise | fall;
    end
endmodule

// File: rtl/dacc_cmp.sv
module dacc_cmp #(
    parameter int TW = 16
) (
    input  logic [TW-1:0] tbase,
    input  logic [TW-1:0] ref_val,
    input  logic          armed,
    output logic          hit
);
    always_comb hit = armed && (tbase == ref_val);
endmodule

// File: rtl/dacc_regb.sv
module dacc_regb
    import dacc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic          sw_wr,
    input  logic [TW-1:0] sw_data,
    input  logic [TW-1:0] tval,
    input  logic          lead_ld,
    input  logic          commit,
    input  logic          cap_ld,
    input  logic          xfer,
    output logic [TW-1:0] b2_o,
    output logic [TW-1:0] view_o
);
    logic [TW-1:0] b1_q;
    logic [TW-1:0] b2_q;
    logic          sw_hits_b1;
    logic          sw_hits_b2;

    always_comb begin
        sw_hits_b1 = sw_wr && ((mode == M_OFF) || (mode == M_PWM));
        sw_hits_b2 = sw_wr && (mode != M_PWM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b1_q <= '0;
        end else if (sw_hits_b1) begin
            b1_q <= sw_data;
        end else if (lead_ld) begin
            b1_q <= tval;
        end
    end

    // hardware events take priority over a software write to B2
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b2_q <= '0;
        end else if (commit) begin
            b2_q <= b1_q;
        end else if (cap_ld) begin
            b2_q <= tval;
        end else if (xfer) begin
            b2_q <= b1_q;
        end else if (sw_hits_b2) begin
            b2_q <= sw_data;
        end
    end

    always_comb begin
        b2_o   = b2_q;
        view_o = ((mode == M_OFF) || (mode == M_PWM)) ? b1_q : b2_q;
    end

    AST_OFF_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_OFF && sw_wr) |=> (b1_q == b2_q)); // R1
    AST_PW_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_PWCAP && !commit && !sw_wr) |=> $stable(b2_q)); // R3
    AST_PWM_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_PWM && xfer) |=> (b2_q == $past(b1_q))); // R8
endmodule

// File: rtl/dacc_channel.sv
module dacc_channel
    import dacc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tbase,
    input  logic          pin_in,
    output logic          pin_out,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [TW-1:0] wr_data,
    output logic [TW-1:0] rd_data
);
    localparam int CTRL_W = 5;

    mode_e         mode_q, mode_d;
    logic          fall_sel_q, lvl_q;
    logic [TW-1:0] rega_q;
    logic [1:0]    flag_q;
    logic          arm_a_q, arm_b_q;
    logic          pin_q, pin_d;

    logic wr_ctrl, wr_a, wr_b, wr_flg;
    logic lead, trail, any_edge;
    logic lead_ld, commit, cap_ld, xfer, per_ld;
    logic eff_arm_a, eff_arm_b, hit_a, hit_b;
    logic set_fa, set_fb;
    logic [TW-1:0] b2_val, b_view;

    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_a    = wr_en && (addr == A_REGA);
        wr_b    = wr_en && (addr == A_REGB);
        wr_flg  = wr_en && (addr == A_FLAG);
    end

    // mode state: next-state logic
    always_comb begin
        mode_d = mode_q;
        if (wr_ctrl) mode_d = decode_mode(wr_data[2:0]);
    end

    // mode state: register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= M_OFF;
            fall_sel_q <= 1'b0;
            lvl_q      <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (wr_ctrl) begin
                fall_sel_q <= wr_data[3];
                lvl_q      <= wr_data[4];
            end
        end
    end

    dacc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .fall_sel(fall_sel_q),
        .lead(lead), .trail(trail), .any_edge(any_edge)
    );

    always_comb begin
        lead_ld = 1'b0;
        commit  = 1'b0;
        per_ld  = 1'b0;
        cap_ld  = 1'b0;
        unique case (mode_q)
            M_PWCAP:  begin lead_ld = lead; commit = trail; end
            M_PERCAP: begin per_ld = lead; cap_ld = lead; end
            M_CAP:    cap_ld = any_edge;
            M_OFF, M_OCB, M_OCAB, M_PWM: ;
            default: ;
        endcase
        eff_arm_a = (mode_q == M_PWM) || (mode_q == M_OCAB && arm_a_q);
        eff_arm_b = (mode_q == M_PWM) || (is_oc(mode_q) && arm_b_q);
    end

    dacc_cmp #(.TW(TW)) u_cmp_a (.tbase(tbase), .ref_val(rega_q), .armed(eff_arm_a), .hit(hit_a));
    dacc_cmp #(.TW(TW)) u_cmp_b (.tbase(tbase), .ref_val(b2_val), .armed(eff_arm_b), .hit(hit_b));

    always_comb begin
        xfer   = (mode_q == M_PWM) && hit_a;
        set_fa = hit_a || commit;
        set_fb = hit_b || cap_ld;
    end

    dacc_regb #(.TW(TW)) u_regb (
        .clk(clk), .rst_n(rst_n), .mode(mode_q),
        .sw_wr(wr_b), .sw_data(wr_data), .tval(tbase),
        .lead_ld(lead_ld), .commit(commit), .cap_ld(cap_ld), .xfer(xfer),
        .b2_o(b2_val), .view_o(b_view)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rega_q <= '0;
        end else if (commit) begin
            rega_q <= tbase;
        end else if (per_ld) begin
            rega_q <= b2_val;
        end else if (wr_a) begin
            rega_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_a_q <= 1'b0;
            arm_b_q <= 1'b0;
        end else if (wr_ctrl) begin
            arm_a_q <= 1'b0;
            arm_b_q <= 1'b0;
        end else begin
            if (wr_a && mode_q == M_OCAB) arm_a_q <= 1'b1;
            else if (hit_a)               arm_a_q <= 1'b0;
            if (wr_b && is_oc(mode_q))    arm_b_q <= 1'b1;
            else if (hit_b)               arm_b_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 2'b00;
        end else begin
            flag_q[0] <= set_fa | (flag_q[0] & ~(wr_flg & wr_data[0]));
            flag_q[1] <= set_fb | (flag_q[1] & ~(wr_flg & wr_data[1]));
        end
    end

    // output process: pin next value per mode
    always_comb begin
        pin_d = pin_q;
        unique case (mode_q)
            M_OCB:  if (hit_b) pin_d = lvl_q;
            M_OCAB, M_PWM: begin
                if (hit_b)      pin_d = 1'b0;
                else if (hit_a) pin_d = 1'b1;
            end
            M_OFF, M_PWCAP, M_PERCAP, M_CAP: pin_d = 1'b0;
            default: pin_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    always_comb begin
        pin_out = pin_q;
        unique case (addr)
            A_CTRL:  rd_data = {{(TW-CTRL_W){1'b0}}, lvl_q, fall_sel_q, mode_q};
            A_REGA:  rd_data = rega_q;
            A_REGB:  rd_data = b_view;
            default: rd_data = {{(TW-2){1'b0}}, flag_q};
        endcase
    end

    AST_ARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_oc(mode_q) && hit_b && !wr_b && !wr_ctrl) |=> !arm_b_q); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> flag_q[1]); // R9
    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!drives_pin(mode_q) && $past(!drives_pin(mode_q))) |-> !pin_q); // R10
    AST_CAPA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_PWCAP && trail) |=> (flag_q[0] && rega_q == $past(tbase))); // R3
endmodule

// File: tb/tb_dacc_channel.sv
module tb_dacc_channel;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tbase = '0;
    logic          pin_in = 1'b0;
    logic          pin_out;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [TW-1:0] wr_data = '0;
    logic [TW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    dacc_channel #(.TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .tbase(tbase), .pin_in(pin_in), .pin_out(pin_out),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [TW-1:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic drive(input logic [TW-1:0] t, input logic p);
        @(negedge clk);
        tbase = t; pin_in = p;
        @(posedge clk); #1;
    endtask

    function automatic int ctrl_word(input int mode, input int fall_sel, input int lvl);
        return (lvl << 4) | (fall_sel << 3) | mode;
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int prev_p;
        int exp_b;
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset state
        rd(2'd0, v); chk("R2", "ctrl", v, 0);
        rd(2'd1, v); chk("R2", "A", v, 0);
        rd(2'd2, v); chk("R2", "B", v, 0);
        rd(2'd3, v); chk("R2", "flags", v, 0);
        chk("R2", "pin", int'(pin_out), 0);

        // R1 mirror in OFF
        wr(2'd2, 16'h1234);
        rd(2'd2, v); chk("R1", "B in OFF", v, 16'h1234);

        // R3 pulse-width capture, R11 control readback
        wr(2'd0, 16'(ctrl_word(1, 0, 0)));
        rd(2'd0, v); chk("R11", "ctrl readback", v, 1);
        rd(2'd2, v); chk("R1", "B2 mirror visible", v, 16'h1234);
        drive(16'h0111, 1'b1);
        rd(2'd2, v); chk("R3", "B hidden at leading edge", v, 16'h1234);
        drive(16'h0222, 1'b0);
        rd(2'd2, v); chk("R3", "B leading time", v, 16'h0111);
        rd(2'd1, v); chk("R3", "A trailing time", v, 16'h0222);
        rd(2'd3, v); chk("R9", "flag A set", v, 1);
        drive(16'h0230, 1'b0);
        rd(2'd3, v); chk("R9", "flag sticky", v, 1);
        wr(2'd3, 16'h0003);
        rd(2'd3, v); chk("R9", "flags cleared", v, 0);

        // R4 period capture
        wr(2'd0, 16'(ctrl_word(2, 0, 0)));
        drive(16'h0333, 1'b1);
        rd(2'd1, v); chk("R4", "A previous B", v, 16'h0111);
        drive(16'h03a0, 1'b0);
        rd(2'd2, v); chk("R4", "falling ignored", v, 16'h0333);
        drive(16'h0444, 1'b1);
        rd(2'd2, v); chk("R4", "B period edge", v, 16'h0444);
        rd(2'd1, v); chk("R4", "A prior edge", v, 16'h0333);
        rd(2'd3, v); chk("R4", "flag B", v, 2);
        wr(2'd0, 16'(ctrl_word(2, 1, 0)));
        drive(16'h0555, 1'b0);
        rd(2'd2, v); chk("R4", "falling selected", v, 16'h0555);
        chk("R10", "pin idle in capture", int'(pin_out), 0);
        wr(2'd3, 16'h0003);

        // R5 capture on any edge, random
        wr(2'd0, 16'(ctrl_word(3, 0, 0)));
        prev_p = 0;
        exp_b = 16'h0555;
        for (int i = 0; i < 60; i++) begin
            int t;
            int p;
            t = int'($urandom_range(0, 16'hffff));
            p = int'($urandom_range(0, 1));
            drive(16'(t), 1'(p));
            if (p != prev_p) exp_b = t;
            prev_p = p;
            rd(2'd2, v); chk("R5", "B last edge", v, exp_b);
        end
        rd(2'd3, v); chk("R5", "flag B after edges", v & 2, 2);
        wr(2'd3, 16'h0003);

        // R6 output compare A and B
        drive(16'h0000, 1'b0);
        wr(2'd0, 16'(ctrl_word(5, 0, 0)));
        wr(2'd1, 16'd300);
        wr(2'd2, 16'd310);
        drive(16'd300, 1'b0);
        chk("R6", "pin set by A", int'(pin_out), 1);
        drive(16'd310, 1'b0);
        chk("R6", "pin cleared by B", int'(pin_out), 0);
        rd(2'd3, v); chk("R6", "both flags", v, 3);
        wr(2'd3, 16'h0003);
        drive(16'd300, 1'b0);
        chk("R6", "A disarmed", int'(pin_out), 0);
        drive(16'd310, 1'b0);
        rd(2'd3, v); chk("R6", "no rematch", v, 0);
        wr(2'd2, 16'd320);
        drive(16'd320, 1'b0);
        rd(2'd3, v); chk("R6", "B write rearms", v, 2);

        // R7 OCB level
        drive(16'h0000, 1'b0);
        wr(2'd0, 16'(ctrl_word(4, 0, 1)));
        wr(2'd2, 16'd400);
        chk("R7", "pin before match", int'(pin_out), 0);
        drive(16'd400, 1'b0);
        chk("R7", "pin driven to level", int'(pin_out), 1);

        // R8 PWM
        wr(2'd0, 16'(ctrl_word(6, 0, 0)));
        wr(2'd2, 16'd100);
        wr(2'd1, 16'd50);
        drive(16'd50, 1'b0);
        chk("R8", "pin set at A", int'(pin_out), 1);
        rd(2'd2, v); chk("R8", "B reads B1", v, 100);
        drive(16'd100, 1'b0);
        chk("R8", "pin cleared at B2", int'(pin_out), 0);
        wr(2'd2, 16'd120);
        drive(16'd50, 1'b0);
        chk("R8", "new period", int'(pin_out), 1);
        wr(2'd2, 16'd200);
        drive(16'd200, 1'b0);
        chk("R8", "width change deferred", int'(pin_out), 1);
        drive(16'd120, 1'b0);
        chk("R8", "old width ends", int'(pin_out), 0);
        for (int i = 0; i < 8; i++) begin
            int a;
            int b;
            a = int'($urandom_range(1000, 30000));
            b = a + int'($urandom_range(1, 1000));
            wr(2'd2, 16'(b));
            wr(2'd1, 16'(a));
            drive(16'(a), 1'b0);
            chk("R8", "random set", int'(pin_out), 1);
            drive(16'(b), 1'b0);
            chk("R8", "random clear", int'(pin_out), 0);
        end
        drive(16'd30, 1'b0);
        drive(16'd30, 1'b0);
        drive(16'd50, 1'b0);

        // R10 reserved code, pin idle
        wr(2'd0, 16'h0007);
        drive(16'd51, 1'b0);
        chk("R10", "pin idle in OFF", int'(pin_out), 0);
        rd(2'd0, v); chk("R10", "reserved reads 0", v, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule